// File: doc/BRIEF.md
# DAC Channel Power Sequencer

This block sits on the host side of a four-channel digital-to-analog converter and produces the 24-bit write commands that configure the converter and switch its channels on and off. It keeps a shadow copy of each channel's output-control word. Every change it makes is a read-modify-write of that shadow, so a power change never disturbs the mode and resistor bits that were set at start-up.

After reset the block runs a fixed start-up series of writes. The series programs the boost-converter settings, then each channel's slew settings, then each channel's initial control word. After that, the block watches a per-channel level input that gives the wanted power state. Whenever a channel's wanted state differs from the state the block recorded, it runs the matching sequence:
- Turning a channel on takes two writes separated by a timed settle interval.
- Turning a channel off takes one write.

Channels that are waiting are served lowest index first. Commands leave through a valid/ready handshake to an SPI master, which does the actual shifting.

Top module: `dacpwr_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `frm_valid` is low; after reset `pwr_down_mask` reads 4'b1111 and stays so until a power-up sequence completes.
- R2: After reset, nine frames go out in this order: one boost-converter write on channel 0 (selector 3, word = `cfg_dcdc`); then slew writes for channels 0,1,2,3 (selector 0, word = that channel's 13-bit slice of `cfg_slew`); then control writes for channels 0,1,2,3 (selector 2).
- R3: The start-up control word for a channel has the mode code in bits 2:0. Bit 5 is set when `cfg_ext_rsense` is low for that channel. Bit 3 is set when `cfg_ovr` is high. All other bits are zero.
- R4: A mode code of 7 is rejected, and so is a code of 0..3 when `HAS_VOLT` is 0. At the first rejected channel the start-up series stops with no frame for that channel or any later one. `cfg_err` goes high and stays high, and no further frames are sent.
- R5: Every frame has bits 23:21 zero, bits 20:16 equal to 0x1C plus the channel number, bits 15:13 holding the selector, and bits 12:0 holding the word.
- R6: Power-up sends two control frames. The first has the shadow word with bits 8 and 4 set. The second has that word with bit 6 also set.
- R7: With `frm_ready` held high, the second power-up frame is accepted exactly SETTLE_CYC+2 cycles after the first, where SETTLE_CYC = (CLK_HZ/1_000_000)*SETTLE_US. No frame is offered during the settle interval.
- R8: Power-down sends one control frame whose word is the shadow word with bits 8, 6 and 4 cleared.
- R9: A channel whose `want_down` bit already equals its `pwr_down_mask` bit causes no frame.
- R10: Differences between the wanted and the recorded state that exist during start-up or during another channel's sequence wait for that work to finish. They are then served one channel at a time, lowest channel index first.
- R11: While `frm_valid` is high and `frm_ready` is low, `frm_valid` stays high and `frm_data` stays unchanged.
- R12: A channel's `pwr_down_mask` bit changes only in the cycle after the last frame of that channel's sequence is accepted: it goes to 0 after the second power-up frame and to 1 after the power-down frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| want_down | input | NCH | Wanted power state per channel, 1 = off |
| cfg_mode | input | 3*NCH | Output mode code per channel |
| cfg_ext_rsense | input | NCH | Channel uses an external sense resistor |
| cfg_ovr | input | NCH | Over-range enable per channel |
| cfg_slew | input | 13*NCH | Slew settings word per channel |
| cfg_dcdc | input | 7 | Boost-converter settings word |
| frm_valid | output | 1 | Command frame offered |
| frm_ready | input | 1 | SPI master takes the frame |
| frm_data | output | 24 | Command frame |
| pwr_down_mask | output | NCH | Recorded power state per channel, 1 = off |
| cfg_err | output | 1 | Start-up stopped on a rejected mode |

## Verification
Three situations are hard to reach from the ports.

The first is a power request that exists before start-up has finished, which must wait until the ninth frame is out. The bench holds `want_down` at a non-idle value straight through reset.

The second is several channels waiting at once, which must be served in index order. The bench changes all four wanted bits in a single cycle.

The third is stalling the handshake, which the bench does by holding `frm_ready` low right after reset. A separate reset with an invalid mode in channel 1 drives the start-up series into its rejection stop.

// File: rtl/dacpwr_pkg.sv
package dacpwr_pkg;

    localparam int FRAME_W = 24;
    localparam int WORD_W  = 13;
    localparam int MODE_W  = 3;
    localparam int DCDC_W  = 7;

    localparam logic [4:0] CTRL_ADDR_BASE = 5'h1C;

    typedef enum logic [2:0] {
        SUB_SLEW = 3'd0,
        SUB_MAIN = 3'd1,
        SUB_DAC  = 3'd2,
        SUB_DCDC = 3'd3
    } sub_e;

    localparam logic [WORD_W-1:0] EN_INTERNAL = 13'h100;
    localparam logic [WORD_W-1:0] EN_OUTPUT   = 13'h040;
    localparam logic [WORD_W-1:0] RSENSE_INT  = 13'h020;
    localparam logic [WORD_W-1:0] EN_BOOST    = 13'h010;
    localparam logic [WORD_W-1:0] OVR_ON      = 13'h008;

    localparam logic [WORD_W-1:0] UP_FIRST_SET = EN_INTERNAL | EN_BOOST;
    localparam logic [WORD_W-1:0] OFF_CLEAR    = EN_INTERNAL | EN_BOOST | EN_OUTPUT;

    typedef enum logic [3:0] {
        ST_DCDC, ST_SLEW, ST_DACW, ST_IDLE,
        ST_UP1, ST_WAIT, ST_UP2, ST_DOWN, ST_HALT
    } st_e;

    typedef struct packed {
        logic [2:0]        rsv;
        logic [4:0]        addr;
        sub_e              sub;
        logic [WORD_W-1:0] word;
    } frame_t;

    function automatic frame_t make_frame(input logic [4:0] ch, input sub_e sub,
                                          input logic [WORD_W-1:0] word);
        frame_t f;
        f.rsv  = 3'b000;
        f.addr = CTRL_ADDR_BASE | ch;
        f.sub  = sub;
        f.word = word;
        return f;
    endfunction

    function automatic logic mode_ok(input logic [MODE_W-1:0] m, input logic has_volt);
        if (m <= 3'd3) return has_volt;
        return (m <= 3'd6);
    endfunction

    function automatic logic [WORD_W-1:0] init_word(input logic [MODE_W-1:0] m,
                                                    input logic ext, input logic ovr);
        logic [WORD_W-1:0] w;
        w = {{(WORD_W-MODE_W){1'b0}}, m};
        if (!ext) w = w | RSENSE_INT;
        if (ovr)  w = w | OVR_ON;
        return w;
    endfunction

endpackage

// File: rtl/dacpwr_pick.sv
module dacpwr_pick #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    output logic           found,
    output logic [IW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dacpwr_settle.sv
module dacpwr_settle #(
    parameter int unsigned CYC = 50000,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(CYC - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

    // R7
    restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);
endmodule

// File: rtl/dacpwr_seq.sv
module dacpwr_seq
    import dacpwr_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CLK_HZ    = 250_000_000,
    parameter int SETTLE_US = 200,
    parameter bit HAS_VOLT  = 1'b1,
    localparam int IW         = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        want_down,
    input  logic [NCH*MODE_W-1:0] cfg_mode,
    input  logic [NCH-1:0]        cfg_ext_rsense,
    input  logic [NCH-1:0]        cfg_ovr,
    input  logic [NCH*WORD_W-1:0] cfg_slew,
    input  logic [DCDC_W-1:0]     cfg_dcdc,
    output logic                  frm_valid,
    input  logic                  frm_ready,
    output logic [FRAME_W-1:0]    frm_data,
    output logic [NCH-1:0]        pwr_down_mask,
    output logic                  cfg_err
);
    st_e               state;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] shadow [NCH];
    logic [NCH-1:0]    mask_q;
    logic              vld_q;
    frame_t            frm_q;
    logic [WORD_W-1:0] pend_word;
    logic              err_q;

    logic              issue;
    sub_e              cur_sub;
    logic [WORD_W-1:0] cur_word;
    logic [MODE_W-1:0] cur_mode;
    logic              pick_found;
    logic [IW-1:0]     pick_idx;
    logic              accept;
    logic              settle_done;
    logic              last_ch;

    assign cur_mode = cfg_mode[int'(idx)*MODE_W +: MODE_W];
    assign accept   = vld_q && frm_ready;
    assign last_ch  = (idx == IW'(NCH - 1));

    always_comb begin
        issue    = 1'b1;
        cur_sub  = SUB_DAC;
        cur_word = '0;
        case (state)
            ST_DCDC: begin
                cur_sub  = SUB_DCDC;
                cur_word = {{(WORD_W-DCDC_W){1'b0}}, cfg_dcdc};
            end
            ST_SLEW: begin
                cur_sub  = SUB_SLEW;
                cur_word = cfg_slew[int'(idx)*WORD_W +: WORD_W];
            end
            ST_DACW: cur_word = init_word(cur_mode, cfg_ext_rsense[idx], cfg_ovr[idx]);
            ST_UP1:  cur_word = shadow[idx] | UP_FIRST_SET;
            ST_UP2:  cur_word = shadow[idx] | EN_OUTPUT;
            ST_DOWN: cur_word = shadow[idx] & ~OFF_CLEAR;
            default: issue = 1'b0;
        endcase
    end

    dacpwr_pick #(.NCH(NCH)) u_pick (
        .req   (want_down ^ mask_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    dacpwr_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (accept && (state == ST_UP1)),
        .done  (settle_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_DCDC;
            idx       <= '0;
            mask_q    <= '1;
            vld_q     <= 1'b0;
            frm_q     <= '0;
            pend_word <= '0;
            err_q     <= 1'b0;
            for (int i = 0; i < NCH; i++) shadow[i] <= '0;
        end else if (issue) begin
            if (!vld_q) begin
                if (state == ST_DACW && !mode_ok(cur_mode, HAS_VOLT)) begin
                    state <= ST_HALT;
                    err_q <= 1'b1;
                end else begin
                    frm_q     <= make_frame(5'(idx), cur_sub, cur_word);
                    pend_word <= cur_word;
                    vld_q     <= 1'b1;
                end
            end else if (frm_ready) begin
                vld_q <= 1'b0;
                if (cur_sub == SUB_DAC) shadow[idx] <= pend_word;
                case (state)
                    ST_DCDC: begin
                        state <= ST_SLEW;
                        idx   <= '0;
                    end
                    ST_SLEW: begin
                        state <= last_ch ? ST_DACW : ST_SLEW;
                        idx   <= last_ch ? '0 : idx + 1'b1;
                    end
                    ST_DACW: begin
                        state <= last_ch ? ST_IDLE : ST_DACW;
                        idx   <= last_ch ? idx : idx + 1'b1;
                    end
                    ST_UP1: state <= ST_WAIT;
                    ST_UP2: begin
                        state       <= ST_IDLE;
                        mask_q[idx] <= 1'b0;
                    end
                    ST_DOWN: begin
                        state       <= ST_IDLE;
                        mask_q[idx] <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end else begin
            case (state)
                ST_IDLE: if (pick_found) begin
                    idx   <= pick_idx;
                    state <= want_down[pick_idx] ? ST_DOWN : ST_UP1;
                end
                ST_WAIT: if (settle_done) state <= ST_UP2;
                default: ;
            endcase
        end
    end

    assign frm_valid     = vld_q;
    assign frm_data      = frm_q;
    assign pwr_down_mask = mask_q;
    assign cfg_err       = err_q;

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data)));

    // R12
    mask_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down_mask != $past(pwr_down_mask)) |->
            ($past(frm_valid && frm_ready) && $countones(pwr_down_mask ^ $past(pwr_down_mask)) == 1));

    // R7
    settle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> !frm_valid);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> (cfg_err && !frm_valid));

    // R6
    out_after_int_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_q.sub == SUB_DAC && frm_q.word[6]) |-> (frm_q.word[8] && frm_q.word[4]));
endmodule

// File: tb/dacpwr_seq_bench.sv
`timescale 1ns/1ps
module dacpwr_seq_bench;
    localparam int S = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  want_down = 4'hF;
    logic [11:0] cfg_mode = {3'd3, 3'd6, 3'd1, 3'd4};
    logic [3:0]  cfg_ext_rsense = 4'b0110;
    logic [3:0]  cfg_ovr = 4'b1010;
    logic [51:0] cfg_slew = {13'h1023, 13'h101A, 13'h1011, 13'h1008};
    logic [6:0]  cfg_dcdc = 7'h25;
    logic        frm_valid;
    logic        frm_ready = 1'b1;
    logic [23:0] frm_data;
    logic [3:0]  pwr_down_mask;
    logic        cfg_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nfr = 0;
    logic [23:0] log_d [64];
    int          log_c [64];

    always #2 clk = ~clk;

    dacpwr_seq #(.NCH(4), .CLK_HZ(1_000_000), .SETTLE_US(S), .HAS_VOLT(1'b1)) u_dacpwr_seq (
        .clk(clk), .rst(rst), .want_down(want_down), .cfg_mode(cfg_mode),
        .cfg_ext_rsense(cfg_ext_rsense), .cfg_ovr(cfg_ovr), .cfg_slew(cfg_slew),
        .cfg_dcdc(cfg_dcdc), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_data(frm_data), .pwr_down_mask(pwr_down_mask), .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && frm_valid && frm_ready && nfr < 64) begin
            log_d[nfr] <= frm_data;
            log_c[nfr] <= cyc;
            nfr <= nfr + 1;
        end
    end

    function automatic logic [23:0] ef(input int ch, input int sel, input int w);
        return {3'b000, 5'(28 + ch), 3'(sel), 13'(w)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 4000 && nfr < target; i++) step(1);
        step(2);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        @(negedge clk);
        chk("R1 valid low in reset", {31'b0, frm_valid}, 32'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid low first cycle", {31'b0, frm_valid}, 32'd0);
        chk("R1 mask after reset", {28'b0, pwr_down_mask}, 32'hF);
    endtask

    task automatic check_init(input int b);
        chk("R2 dcdc frame", log_d[b], ef(0, 3, 7'h25));
        chk("R2 slew ch0", log_d[b+1], ef(0, 0, 13'h1008));
        chk("R2 slew ch1", log_d[b+2], ef(1, 0, 13'h1011));
        chk("R2 slew ch2", log_d[b+3], ef(2, 0, 13'h101A));
        chk("R2 slew ch3", log_d[b+4], ef(3, 0, 13'h1023));
        chk("R3 ctrl ch0", log_d[b+5], ef(0, 2, 13'h024));
        chk("R3 ctrl ch1", log_d[b+6], ef(1, 2, 13'h009));
        chk("R3 ctrl ch2", log_d[b+7], ef(2, 2, 13'h006));
        chk("R5 ctrl ch3", log_d[b+8], ef(3, 2, 13'h02B));
    endtask

    task automatic t_init_stall();
        logic [23:0] held;
        int b;
        frm_ready = 1'b0;
        want_down = 4'hF;
        b = nfr;
        do_reset();
        step(3);
        @(negedge clk);
        held = frm_data;
        chk("R11 valid while stalled", {31'b0, frm_valid}, 32'd1);
        step(4);
        @(negedge clk);
        chk("R11 data held", frm_data, held);
        chk("R11 held frame", frm_data, ef(0, 3, 7'h25));
        @(posedge clk); #1;
        frm_ready = 1'b1;
        wait_frames(b + 9);
        chk("R2 init count", nfr - b, 9);
        check_init(b);
        chk("R1 mask after init", {28'b0, pwr_down_mask}, 32'hF);
    endtask

    task automatic t_same_state();
        int b;
        b = nfr;
        want_down = 4'hF;
        step(60);
        chk("R9 no frames when matching", nfr - b, 0);
    endtask

    task automatic t_up_down();
        int b;
        b = nfr;
        want_down = 4'b1011;
        step(8);
        chk("R12 mask unchanged mid sequence", {28'b0, pwr_down_mask}, 32'hF);
        wait_frames(b + 2);
        chk("R6 up count", nfr - b, 2);
        chk("R6 up first", log_d[b], ef(2, 2, 13'h116));
        chk("R6 up second", log_d[b+1], ef(2, 2, 13'h156));
        chk("R7 settle gap", log_c[b+1] - log_c[b], S + 2);
        chk("R12 mask after up", {28'b0, pwr_down_mask}, 32'hB);
        b = nfr;
        want_down = 4'hF;
        wait_frames(b + 1);
        step(40);
        chk("R8 down count", nfr - b, 1);
        chk("R8 down frame", log_d[b], ef(2, 2, 13'h006));
        chk("R12 mask after down", {28'b0, pwr_down_mask}, 32'hF);
    endtask

    task automatic t_queue();
        int b;
        b = nfr;
        want_down = 4'h0;
        wait_frames(b + 8);
        step(40);
        chk("R10 queue count", nfr - b, 8);
        chk("R10 ch0 a", log_d[b],   ef(0, 2, 13'h134));
        chk("R10 ch0 b", log_d[b+1], ef(0, 2, 13'h174));
        chk("R10 ch1 a", log_d[b+2], ef(1, 2, 13'h119));
        chk("R10 ch1 b", log_d[b+3], ef(1, 2, 13'h159));
        chk("R10 ch2 a", log_d[b+4], ef(2, 2, 13'h116));
        chk("R10 ch2 b", log_d[b+5], ef(2, 2, 13'h156));
        chk("R10 ch3 a", log_d[b+6], ef(3, 2, 13'h13B));
        chk("R10 ch3 b", log_d[b+7], ef(3, 2, 13'h17B));
        chk("R12 mask all up", {28'b0, pwr_down_mask}, 32'h0);
    endtask

    task automatic t_req_during_init();
        int b;
        b = nfr;
        want_down = 4'b1110;
        do_reset();
        wait_frames(b + 11);
        step(40);
        chk("R10 count with early request", nfr - b, 11);
        check_init(b);
        chk("R10 early ch0 a", log_d[b+9],  ef(0, 2, 13'h134));
        chk("R10 early ch0 b", log_d[b+10], ef(0, 2, 13'h174));
        chk("R12 mask early", {28'b0, pwr_down_mask}, 32'hE);
    endtask

    task automatic t_reject();
        int b;
        b = nfr;
        want_down = 4'hF;
        cfg_mode = {3'd3, 3'd6, 3'd7, 3'd4};
        do_reset();
        step(100);
        chk("R4 frames before stop", nfr - b, 6);
        chk("R4 last frame", log_d[b+5], ef(0, 2, 13'h024));
        chk("R4 err flag", {31'b0, cfg_err}, 32'd1);
        b = nfr;
        want_down = 4'h0;
        step(100);
        chk("R4 no frames after stop", nfr - b, 0);
        chk("R4 mask untouched", {28'b0, pwr_down_mask}, 32'hF);
        chk("R4 err stays", {31'b0, cfg_err}, 32'd1);
    endtask

    initial begin
        t_init_stall();
        t_same_state();
        t_up_down();
        t_queue();
        t_req_during_init();
        t_reject();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule